// File: doc/BRIEF.md
# Miss Status Holding Register File

This block tracks outstanding misses for a non-blocking cache. A pool of entries is kept free until a miss arrives. An allocate command then claims the lowest-numbered free entry and records the miss there: its block address, access size, secure flag, thread number and the earliest time at which it may be sent downstream. The surrounding cache issues these entries to memory, moves them between the pending and in-service states, and frees them when the fill returns. Target lists, data storage and the memory side are outside this block.

Two lookups run combinationally over every entry. The exact lookup reports every allocated entry whose address and secure flag equal the probe, and is used to merge a new request into an existing miss. The pending lookup reports an unissued entry whose byte range overlaps a probe range with the same secure flag, and is used for ordering hazards. The issue selector names the next pending entry to send. It is ordered by ready time, with ties going to the earlier arrival, and a single entry may be forced to the front. A squash by thread number, and a drain handshake that reports when the file has emptied, complete the command set.

The drain control is a three-state machine. RUN is normal operation. DRAINING is entered by a drain command while entries are allocated. DRAINED is entered from RUN by a drain command on an empty file (transition "drain-empty"), or from DRAINING when the allocated count reaches zero (transition "emptied"). DRAINED returns to RUN on an accepted allocation (transition "reopen"). A drain command in DRAINED pulses done again and stays there.

Top module: `miss_track_file`

## Requirements
- R1: The file holds REQ_ENTRIES + RESERVE - 1 entries (5 by default). An allocate command (cmd_op = 1) with a free entry writes that entry, takes the lowest free index (shown beforehand on alloc_idx), and raises alloc_count by one at the next clock edge.
- R2: full is high while alloc_count >= entry count - RESERVE. An allocate with no free entry changes no state and pulses alloc_err for one cycle.
- R3: match_mask has bit i set when entry i is allocated and its address and secure flag equal probe_addr and probe_secure. match_hit is the OR of the mask, and match_idx is the lowest set bit.
- R4: pend_hit and pend_idx (the lowest index) report an allocated entry that is not in service, has a secure flag equal to pend_secure, and whose range [addr, addr+size) overlaps [pend_addr, pend_addr+pend_size).
- R5: issue_valid and issue_idx name the pending entry with ready time <= now that has the smallest ready time. Among equal ready times, the entry allocated or re-pended earliest wins.
- R6: Mark-in-service (cmd_op = 3) on a pending entry removes it from issue and raises svc_count by one. Mark-pending (cmd_op = 4) on an in-service entry lowers svc_count by one and reinserts the entry as the latest arrival.
- R7: Free (cmd_op = 2) on an allocated entry returns it to the pool and lowers alloc_count by one. If the entry was in service, svc_count also drops by one.
- R8: Move-to-front (cmd_op = 5) on a pending entry makes it issue ahead of all others, whatever its ready time. On an in-service entry it has no effect.
- R9: Squash (cmd_op = 6) frees every pending entry whose thread equals squash_tid. Matching in-service entries stay allocated.
- R10: A drain command (cmd_op = 7) on an empty file pulses drain_done at the next edge. Otherwise drain_busy rises, and drain_done pulses in the cycle in which alloc_count becomes zero.
- R11: After reset, alloc_count and svc_count are 0, and full, issue_valid, alloc_err, drain_busy and drain_done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_op | input | 3 | Command: 0 none, 1 allocate, 2 free, 3 mark in service, 4 mark pending, 5 move to front, 6 squash, 7 drain |
| cmd_idx | input | IDX_W | Target entry for free, mark and move commands |
| new_addr | input | ADDR_W | Block address for allocate |
| new_size | input | SIZE_W | Access size in bytes for allocate |
| new_secure | input | 1 | Secure flag for allocate |
| new_tid | input | TID_W | Thread number for allocate |
| new_ready | input | TIME_W | Ready time for allocate |
| squash_tid | input | TID_W | Thread number for squash |
| now | input | TIME_W | Current time for issue selection |
| probe_addr | input | ADDR_W | Exact lookup address |
| probe_secure | input | 1 | Exact lookup secure flag |
| pend_addr | input | ADDR_W | Overlap lookup start address |
| pend_size | input | SIZE_W | Overlap lookup size |
| pend_secure | input | 1 | Overlap lookup secure flag |
| alloc_idx | output | IDX_W | Entry the next allocate will take |
| alloc_err | output | 1 | One-cycle pulse on allocate with no free entry |
| full | output | 1 | Reserve threshold reached |
| alloc_count | output | CNT_W | Allocated entries |
| svc_count | output | CNT_W | In-service entries |
| issue_valid | output | 1 | An entry is ready to issue |
| issue_idx | output | IDX_W | Entry to issue |
| match_hit | output | 1 | Exact lookup hit |
| match_idx | output | IDX_W | Lowest exact-hit entry |
| match_mask | output | ENTRIES | All exact-hit entries |
| pend_hit | output | 1 | Overlap lookup hit |
| pend_idx | output | IDX_W | Lowest overlapping pending entry |
| drain_busy | output | 1 | Drain waiting for the file to empty |
| drain_done | output | 1 | One-cycle drain completion pulse |

## Verification
A wrong valid or in-service bit shows at the ports as soon as the lookups are probed. alloc_idx, match_mask and pend_hit all read those bits combinationally, so an error is visible in the first cycle after the faulty edge. A corrupted age stamp or front bit stays hidden until two pending entries tie on ready time or one is forced forward. For that reason the bench builds such ties on purpose and reads issue_idx directly after each mark, re-pend and move. A miscounted tally shows up as a missing or early drain_done, or as a wrong full flag on the edge where the threshold is crossed.

// File: rtl/mtf_pkg.sv
package mtf_pkg;
    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_ALLOC  = 3'd1,
        OP_FREE   = 3'd2,
        OP_ISSUE  = 3'd3,
        OP_RETRY  = 3'd4,
        OP_FRONT  = 3'd5,
        OP_SQUASH = 3'd6,
        OP_DRAIN  = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        DS_RUN      = 2'd0,
        DS_DRAINING = 2'd1,
        DS_DRAINED  = 2'd2
    } drain_e;
endpackage

// File: rtl/mtf_lookup.sv
module mtf_lookup #(
    parameter int N      = 5,
    parameter int ADDR_W = 16,
    parameter int SIZE_W = 8,
    parameter int IDX_W  = 3
) (
    input  logic [N-1:0]      e_valid,
    input  logic [N-1:0]      e_svc,
    input  logic [N-1:0]      e_sec,
    input  logic [ADDR_W-1:0] e_addr [N],
    input  logic [SIZE_W-1:0] e_size [N],
    input  logic [ADDR_W-1:0] probe_addr,
    input  logic              probe_secure,
    input  logic [ADDR_W-1:0] pend_addr,
    input  logic [SIZE_W-1:0] pend_size,
    input  logic              pend_secure,
    output logic              match_hit,
    output logic [IDX_W-1:0]  match_idx,
    output logic [N-1:0]      match_mask,
    output logic              pend_hit,
    output logic [IDX_W-1:0]  pend_idx
);
    localparam int EXT_W = ADDR_W + 1;

    logic [N-1:0] ovl;

    // Per-entry comparators, one copy per entry
    for (genvar g = 0; g < N; g++) begin : g_cmp
        logic [EXT_W-1:0] e_lo, e_hi, p_lo, p_hi;
        always_comb begin
            e_lo = {1'b0, e_addr[g]};
            e_hi = e_lo + EXT_W'(e_size[g]);
            p_lo = {1'b0, pend_addr};
            p_hi = p_lo + EXT_W'(pend_size);
            match_mask[g] = e_valid[g] && (e_addr[g] == probe_addr)
                            && (e_sec[g] == probe_secure);
            ovl[g] = e_valid[g] && !e_svc[g] && (e_sec[g] == pend_secure)
                     && ((e_lo < p_lo) ? (e_hi > p_lo) : (p_hi > e_lo));
        end
    end

    // Lowest-index priority for both lookups
    always_comb begin
        match_hit = 1'b0;
        match_idx = '0;
        pend_hit  = 1'b0;
        pend_idx  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match_mask[i]) begin
                match_hit = 1'b1;
                match_idx = IDX_W'(i);
            end
            if (ovl[i]) begin
                pend_hit = 1'b1;
                pend_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/mtf_issue_pick.sv
module mtf_issue_pick #(
    parameter int N       = 5,
    parameter int TIME_W  = 16,
    parameter int STAMP_W = 16,
    parameter int IDX_W   = 3
) (
    input  logic [N-1:0]       e_valid,
    input  logic [N-1:0]       e_svc,
    input  logic [N-1:0]       e_front,
    input  logic [TIME_W-1:0]  e_ready [N],
    input  logic [STAMP_W-1:0] e_stamp [N],
    input  logic [TIME_W-1:0]  now,
    output logic               issue_valid,
    output logic [IDX_W-1:0]   issue_idx
);
    logic [N-1:0] cand;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            cand[i] = e_valid[i] && !e_svc[i]
                      && (e_front[i] || (e_ready[i] <= now));
        end
    end

    // Linear scan keeping the best candidate seen so far
    always_comb begin
        logic              found;
        logic              take;
        logic [IDX_W-1:0]  best;
        found = 1'b0;
        best  = '0;
        for (int i = 0; i < N; i++) begin
            take = 1'b0;
            if (cand[i]) begin
                if (!found) begin
                    take = 1'b1;
                end else if (e_front[best]) begin
                    take = 1'b0;
                end else if (e_front[i]) begin
                    take = 1'b1;
                end else if (e_ready[i] < e_ready[best]) begin
                    take = 1'b1;
                end else if ((e_ready[i] == e_ready[best])
                             && (e_stamp[i] < e_stamp[best])) begin
                    take = 1'b1;
                end
            end
            if (take) begin
                found = 1'b1;
                best  = IDX_W'(i);
            end
        end
        issue_valid = found;
        issue_idx   = best;
    end
endmodule

// File: rtl/mtf_drain_ctl.sv
module mtf_drain_ctl
    import mtf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic drain_req,
    input  logic alloc_go,
    input  logic cur_zero,
    input  logic next_zero,
    output logic drain_busy,
    output logic drain_done
);
    drain_e state, state_nxt;
    logic   done_set;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= DS_RUN;
            drain_done <= 1'b0;
        end else begin
            state      <= state_nxt;
            drain_done <= done_set;
        end
    end

    // Next state and outputs
    always_comb begin
        state_nxt = state;
        done_set  = 1'b0;
        unique case (state)
            DS_RUN: begin
                if (drain_req && cur_zero) begin
                    state_nxt = DS_DRAINED;
                    done_set  = 1'b1;
                end else if (drain_req) begin
                    state_nxt = DS_DRAINING;
                end
            end
            DS_DRAINING: begin
                if (next_zero) begin
                    state_nxt = DS_DRAINED;
                    done_set  = 1'b1;
                end
            end
            DS_DRAINED: begin
                if (alloc_go) begin
                    state_nxt = DS_RUN;
                end else if (drain_req) begin
                    done_set = 1'b1;
                end
            end
            default: state_nxt = DS_RUN;
        endcase
        drain_busy = (state == DS_DRAINING);
    end
endmodule

// File: rtl/miss_track_file.sv
module miss_track_file
    import mtf_pkg::*;
#(
    parameter int REQ_ENTRIES = 4,
    parameter int RESERVE     = 2,
    parameter int ADDR_W      = 16,
    parameter int SIZE_W      = 8,
    parameter int TID_W       = 2,
    parameter int TIME_W      = 16,
    parameter int STAMP_W     = 16,
    localparam int ENTRIES    = REQ_ENTRIES + RESERVE - 1,
    localparam int IDX_W      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int CNT_W      = $clog2(ENTRIES + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [2:0]         cmd_op,
    input  logic [IDX_W-1:0]   cmd_idx,
    input  logic [ADDR_W-1:0]  new_addr,
    input  logic [SIZE_W-1:0]  new_size,
    input  logic               new_secure,
    input  logic [TID_W-1:0]   new_tid,
    input  logic [TIME_W-1:0]  new_ready,
    input  logic [TID_W-1:0]   squash_tid,
    input  logic [TIME_W-1:0]  now,
    input  logic [ADDR_W-1:0]  probe_addr,
    input  logic               probe_secure,
    input  logic [ADDR_W-1:0]  pend_addr,
    input  logic [SIZE_W-1:0]  pend_size,
    input  logic               pend_secure,
    output logic [IDX_W-1:0]   alloc_idx,
    output logic               alloc_err,
    output logic               full,
    output logic [CNT_W-1:0]   alloc_count,
    output logic [CNT_W-1:0]   svc_count,
    output logic               issue_valid,
    output logic [IDX_W-1:0]   issue_idx,
    output logic               match_hit,
    output logic [IDX_W-1:0]   match_idx,
    output logic [ENTRIES-1:0] match_mask,
    output logic               pend_hit,
    output logic [IDX_W-1:0]   pend_idx,
    output logic               drain_busy,
    output logic               drain_done
);
    localparam int N         = ENTRIES;
    localparam int FULL_MARK = ENTRIES - RESERVE;

    op_e op;
    assign op = op_e'(cmd_op);

    logic [N-1:0]       e_valid, e_svc, e_sec, e_front;
    logic [ADDR_W-1:0]  e_addr  [N];
    logic [SIZE_W-1:0]  e_size  [N];
    logic [TID_W-1:0]   e_tid   [N];
    logic [TIME_W-1:0]  e_ready [N];
    logic [STAMP_W-1:0] e_stamp [N];
    logic [STAMP_W-1:0] stamp_ctr;

    logic               have_free;
    logic [N-1:0]       sq_mask;
    logic [CNT_W-1:0]   sq_n;
    logic [CNT_W-1:0]   cnt_nxt;
    logic               alloc_go, free_go, issue_go, retry_go, front_go;

    // Lowest free entry and squash set
    always_comb begin
        have_free = 1'b0;
        alloc_idx = '0;
        sq_n      = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!e_valid[i]) begin
                have_free = 1'b1;
                alloc_idx = IDX_W'(i);
            end
        end
        for (int i = 0; i < N; i++) begin
            sq_mask[i] = e_valid[i] && !e_svc[i] && (e_tid[i] == squash_tid);
            sq_n       = sq_n + CNT_W'(sq_mask[i]);
        end
    end

    assign alloc_go = (op == OP_ALLOC) && have_free;
    assign free_go  = (op == OP_FREE)  && e_valid[cmd_idx];
    assign issue_go = (op == OP_ISSUE) && e_valid[cmd_idx] && !e_svc[cmd_idx];
    assign retry_go = (op == OP_RETRY) && e_valid[cmd_idx] && e_svc[cmd_idx];
    assign front_go = (op == OP_FRONT) && e_valid[cmd_idx] && !e_svc[cmd_idx];

    always_comb begin
        cnt_nxt = alloc_count;
        if (alloc_go) begin
            cnt_nxt = alloc_count + 1'b1;
        end else if (free_go) begin
            cnt_nxt = alloc_count - 1'b1;
        end else if (op == OP_SQUASH) begin
            cnt_nxt = alloc_count - sq_n;
        end
    end

    assign full = (alloc_count >= CNT_W'(FULL_MARK));

    // Entry state and tallies
    always_ff @(posedge clk) begin
        if (rst) begin
            e_valid     <= '0;
            e_svc       <= '0;
            e_sec       <= '0;
            e_front     <= '0;
            stamp_ctr   <= '0;
            alloc_count <= '0;
            svc_count   <= '0;
            alloc_err   <= 1'b0;
            for (int i = 0; i < N; i++) begin
                e_addr[i]  <= '0;
                e_size[i]  <= '0;
                e_tid[i]   <= '0;
                e_ready[i] <= '0;
                e_stamp[i] <= '0;
            end
        end else begin
            alloc_err   <= (op == OP_ALLOC) && !have_free;
            alloc_count <= cnt_nxt;
            if (alloc_go) begin
                e_valid[alloc_idx] <= 1'b1;
                e_svc[alloc_idx]   <= 1'b0;
                e_front[alloc_idx] <= 1'b0;
                e_sec[alloc_idx]   <= new_secure;
                e_addr[alloc_idx]  <= new_addr;
                e_size[alloc_idx]  <= new_size;
                e_tid[alloc_idx]   <= new_tid;
                e_ready[alloc_idx] <= new_ready;
                e_stamp[alloc_idx] <= stamp_ctr;
                stamp_ctr          <= stamp_ctr + 1'b1;
            end
            if (free_go) begin
                e_valid[cmd_idx] <= 1'b0;
                e_front[cmd_idx] <= 1'b0;
                if (e_svc[cmd_idx]) begin
                    e_svc[cmd_idx] <= 1'b0;
                    svc_count      <= svc_count - 1'b1;
                end
            end
            if (issue_go) begin
                e_svc[cmd_idx]   <= 1'b1;
                e_front[cmd_idx] <= 1'b0;
                svc_count        <= svc_count + 1'b1;
            end
            if (retry_go) begin
                e_svc[cmd_idx]   <= 1'b0;
                e_stamp[cmd_idx] <= stamp_ctr;
                stamp_ctr        <= stamp_ctr + 1'b1;
                svc_count        <= svc_count - 1'b1;
            end
            if (front_go) begin
                e_front          <= '0;
                e_front[cmd_idx] <= 1'b1;
            end
            if (op == OP_SQUASH) begin
                for (int i = 0; i < N; i++) begin
                    if (sq_mask[i]) begin
                        e_valid[i] <= 1'b0;
                        e_front[i] <= 1'b0;
                    end
                end
            end
        end
    end

    mtf_lookup #(
        .N(N), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .IDX_W(IDX_W)
    ) u_lookup (
        .e_valid(e_valid), .e_svc(e_svc), .e_sec(e_sec),
        .e_addr(e_addr), .e_size(e_size),
        .probe_addr(probe_addr), .probe_secure(probe_secure),
        .pend_addr(pend_addr), .pend_size(pend_size), .pend_secure(pend_secure),
        .match_hit(match_hit), .match_idx(match_idx), .match_mask(match_mask),
        .pend_hit(pend_hit), .pend_idx(pend_idx)
    );

    mtf_issue_pick #(
        .N(N), .TIME_W(TIME_W), .STAMP_W(STAMP_W), .IDX_W(IDX_W)
    ) u_pick (
        .e_valid(e_valid), .e_svc(e_svc), .e_front(e_front),
        .e_ready(e_ready), .e_stamp(e_stamp), .now(now),
        .issue_valid(issue_valid), .issue_idx(issue_idx)
    );

    mtf_drain_ctl u_drain (
        .clk(clk), .rst(rst),
        .drain_req(op == OP_DRAIN),
        .alloc_go(alloc_go),
        .cur_zero(alloc_count == '0),
        .next_zero(cnt_nxt == '0),
        .drain_busy(drain_busy),
        .drain_done(drain_done)
    );
endmodule

// File: rtl/mtf_checker.sv
module mtf_checker #(
    parameter int N     = 5,
    parameter int IDX_W = 3,
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic [2:0]       cmd_op,
    input logic [N-1:0]     e_valid,
    input logic [N-1:0]     e_svc,
    input logic [CNT_W-1:0] alloc_count,
    input logic [CNT_W-1:0] svc_count,
    input logic             alloc_err,
    input logic             issue_valid,
    input logic [IDX_W-1:0] issue_idx,
    input logic             match_hit,
    input logic [IDX_W-1:0] match_idx,
    input logic [N-1:0]     match_mask,
    input logic             drain_done
);
    a_r1_count_tally: assert property (@(posedge clk) disable iff (rst)
        32'(alloc_count) == $countones(e_valid));

    a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (cmd_op == 3'd1 && 32'(alloc_count) == N) |=> (alloc_err && $stable(alloc_count)));

    a_r3_lowest_hit: assert property (@(posedge clk) disable iff (rst)
        match_hit |-> match_mask[match_idx]);

    a_r5_issue_pending: assert property (@(posedge clk) disable iff (rst)
        issue_valid |-> (e_valid[issue_idx] && !e_svc[issue_idx]));

    a_r6_svc_tally: assert property (@(posedge clk) disable iff (rst)
        32'(svc_count) == $countones(e_valid & e_svc));

    a_r10_done_empty: assert property (@(posedge clk) disable iff (rst)
        drain_done |-> (alloc_count == '0));
endmodule

bind miss_track_file mtf_checker #(
    .N(ENTRIES), .IDX_W(IDX_W), .CNT_W(CNT_W)
) u_checker (
    .clk(clk), .rst(rst), .cmd_op(cmd_op),
    .e_valid(e_valid), .e_svc(e_svc),
    .alloc_count(alloc_count), .svc_count(svc_count), .alloc_err(alloc_err),
    .issue_valid(issue_valid), .issue_idx(issue_idx),
    .match_hit(match_hit), .match_idx(match_idx), .match_mask(match_mask),
    .drain_done(drain_done)
);

// File: tb/tb_miss_track_file.sv
module tb_miss_track_file;
    import mtf_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  cmd_op = 3'd0;
    logic [2:0]  cmd_idx = '0;
    logic [15:0] new_addr = '0;
    logic [7:0]  new_size = '0;
    logic        new_secure = 1'b0;
    logic [1:0]  new_tid = '0;
    logic [15:0] new_ready = '0;
    logic [1:0]  squash_tid = '0;
    logic [15:0] now = '0;
    logic [15:0] probe_addr = '0;
    logic        probe_secure = 1'b0;
    logic [15:0] pend_addr = '0;
    logic [7:0]  pend_size = '0;
    logic        pend_secure = 1'b0;
    logic [2:0]  alloc_idx, issue_idx, match_idx, pend_idx;
    logic [2:0]  alloc_count, svc_count;
    logic [4:0]  match_mask;
    logic        alloc_err, full, issue_valid, match_hit, pend_hit;
    logic        drain_busy, drain_done;

    int n_run  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    miss_track_file dut (
        .clk(clk), .rst(rst), .cmd_op(cmd_op), .cmd_idx(cmd_idx),
        .new_addr(new_addr), .new_size(new_size), .new_secure(new_secure),
        .new_tid(new_tid), .new_ready(new_ready), .squash_tid(squash_tid),
        .now(now), .probe_addr(probe_addr), .probe_secure(probe_secure),
        .pend_addr(pend_addr), .pend_size(pend_size), .pend_secure(pend_secure),
        .alloc_idx(alloc_idx), .alloc_err(alloc_err), .full(full),
        .alloc_count(alloc_count), .svc_count(svc_count),
        .issue_valid(issue_valid), .issue_idx(issue_idx),
        .match_hit(match_hit), .match_idx(match_idx), .match_mask(match_mask),
        .pend_hit(pend_hit), .pend_idx(pend_idx),
        .drain_busy(drain_busy), .drain_done(drain_done)
    );

    typedef struct packed {
        logic [15:0] addr;
        logic [7:0]  size;
        logic        sec;
        logic [1:0]  tid;
        logic [15:0] rt;
        logic [2:0]  exp_idx;
        logic        exp_full;
    } vec_t;

    localparam vec_t VEC [5] = '{
        '{16'h0100, 8'd64, 1'b0, 2'd0, 16'd50, 3'd0, 1'b0},
        '{16'h0200, 8'd64, 1'b1, 2'd1, 16'd20, 3'd1, 1'b0},
        '{16'h0300, 8'd32, 1'b0, 2'd1, 16'd20, 3'd2, 1'b1},
        '{16'h0100, 8'd64, 1'b0, 2'd2, 16'd10, 3'd3, 1'b1},
        '{16'h0400, 8'd16, 1'b0, 2'd0, 16'd20, 3'd4, 1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cmd(input op_e op, input logic [2:0] idx);
        @(negedge clk);
        cmd_op  = 3'(op);
        cmd_idx = idx;
        @(posedge clk);
        #2;
        cmd_op = 3'(OP_NOP);
    endtask

    task automatic exact(input logic [15:0] a, input logic s);
        probe_addr = a;
        probe_secure = s;
        #1;
    endtask

    task automatic pend(input logic [15:0] a, input logic [7:0] sz, input logic s);
        pend_addr = a;
        pend_size = sz;
        pend_secure = s;
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired (all requirements)");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        #1;
        // R11 reset state
        chk("R11 alloc_count", 32'(alloc_count), 0);
        chk("R11 svc_count", 32'(svc_count), 0);
        chk("R11 full", 32'(full), 0);
        chk("R11 issue_valid", 32'(issue_valid), 0);
        chk("R11 drain outputs", {30'd0, drain_busy, drain_done}, 0);
        chk("R11 alloc_err", 32'(alloc_err), 0);

        // R1/R2 table-driven allocation
        for (int i = 0; i < 5; i++) begin
            new_addr = VEC[i].addr;
            new_size = VEC[i].size;
            new_secure = VEC[i].sec;
            new_tid = VEC[i].tid;
            new_ready = VEC[i].rt;
            #1;
            chk("R1 alloc_idx", 32'(alloc_idx), 32'(VEC[i].exp_idx));
            cmd(OP_ALLOC, 3'd0);
            chk("R1 alloc_count", 32'(alloc_count), 32'(i + 1));
            chk("R2 full", 32'(full), 32'(VEC[i].exp_full));
        end

        // R2 overflow ignored
        new_addr = 16'h0900;
        cmd(OP_ALLOC, 3'd0);
        chk("R2 alloc_err pulse", 32'(alloc_err), 1);
        chk("R2 count unchanged", 32'(alloc_count), 5);
        exact(16'h0900, 1'b0);
        chk("R2 no entry written", 32'(match_hit), 0);
        cmd(OP_NOP, 3'd0);
        chk("R2 alloc_err clears", 32'(alloc_err), 0);

        // R3 exact lookup
        exact(16'h0100, 1'b0);
        chk("R3 mask 0x100", 32'(match_mask), 32'b01001);
        chk("R3 lowest idx", 32'(match_idx), 0);
        exact(16'h0100, 1'b1);
        chk("R3 secure differs", {31'd0, match_hit}, 0);
        exact(16'h0200, 1'b1);
        chk("R3 mask 0x200", 32'(match_mask), 32'b00010);

        // R5 issue order
        now = 16'd5; #1;
        chk("R5 nothing ready", 32'(issue_valid), 0);
        now = 16'd20; #1;
        chk("R5 earliest ready", {issue_valid, 28'd0, issue_idx}, {1'b1, 28'd0, 3'd3});
        now = 16'd100; #1;
        chk("R5 earliest at 100", 32'(issue_idx), 3);

        // R6 in service
        cmd(OP_ISSUE, 3'd3);
        chk("R6 svc_count up", 32'(svc_count), 1);
        chk("R5 tie by arrival", 32'(issue_idx), 1);

        // R4 overlap lookup
        pend(16'h0120, 8'd4, 1'b0);
        chk("R4 inside hit", {pend_hit, 28'd0, pend_idx}, {1'b1, 28'd0, 3'd0});
        pend(16'h00F0, 8'h10, 1'b0);
        chk("R4 touching below", 32'(pend_hit), 0);
        pend(16'h00F0, 8'h11, 1'b0);
        chk("R4 one byte overlap", 32'(pend_hit), 1);
        pend(16'h013F, 8'd1, 1'b0);
        chk("R4 last byte", 32'(pend_hit), 1);
        pend(16'h0140, 8'd1, 1'b0);
        chk("R4 past end", 32'(pend_hit), 0);
        pend(16'h0210, 8'd4, 1'b0);
        chk("R4 secure differs", 32'(pend_hit), 0);
        pend(16'h0210, 8'd4, 1'b1);
        chk("R4 secure equal", {pend_hit, 28'd0, pend_idx}, {1'b1, 28'd0, 3'd1});

        // R6 re-pend goes behind equal ready times
        cmd(OP_ISSUE, 3'd1);
        chk("R6 svc_count 2", 32'(svc_count), 2);
        cmd(OP_RETRY, 3'd1);
        chk("R6 svc_count back", 32'(svc_count), 1);
        chk("R6 re-pend last", 32'(issue_idx), 2);

        // R8 move to front
        cmd(OP_FRONT, 3'd3);
        chk("R8 in-service ignored", 32'(issue_idx), 2);
        cmd(OP_FRONT, 3'd4);
        chk("R8 front wins", 32'(issue_idx), 4);
        now = 16'd0; #1;
        chk("R8 front ignores time", {issue_valid, 28'd0, issue_idx}, {1'b1, 28'd0, 3'd4});
        now = 16'd100; #1;

        // R9 squash
        cmd(OP_ISSUE, 3'd1);
        squash_tid = 2'd1;
        cmd(OP_SQUASH, 3'd0);
        chk("R9 count after squash", 32'(alloc_count), 4);
        exact(16'h0200, 1'b1);
        chk("R9 in-service kept", 32'(match_hit), 1);
        exact(16'h0300, 1'b0);
        chk("R9 pending freed", 32'(match_hit), 0);
        chk("R9 freed slot reused", 32'(alloc_idx), 2);

        // R7 free
        cmd(OP_FREE, 3'd3);
        chk("R7 count", 32'(alloc_count), 3);
        chk("R7 svc_count", 32'(svc_count), 1);
        cmd(OP_FREE, 3'd1);
        chk("R7 svc_count zero", {alloc_count, svc_count}, {3'd2, 3'd0});

        // R4 in-service exclusion
        cmd(OP_ISSUE, 3'd0);
        pend(16'h0120, 8'd4, 1'b0);
        chk("R4 in service excluded", 32'(pend_hit), 0);

        // R10 drain
        cmd(OP_DRAIN, 3'd0);
        chk("R10 busy", {drain_busy, drain_done}, 2'b10);
        cmd(OP_FREE, 3'd0);
        chk("R10 not yet done", {alloc_count, drain_done}, {3'd1, 1'b0});
        cmd(OP_FREE, 3'd4);
        chk("R10 done at empty", {alloc_count, drain_busy, drain_done}, {3'd0, 2'b01});
        cmd(OP_NOP, 3'd0);
        chk("R10 done is a pulse", 32'(drain_done), 0);
        cmd(OP_DRAIN, 3'd0);
        chk("R10 empty drain immediate", {drain_busy, drain_done}, 2'b01);
        cmd(OP_ALLOC, 3'd0);
        chk("R10 reopen", {alloc_count, drain_done}, {3'd1, 1'b0});

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule